// File: doc/BRIEF.md
# Dual-Mode Serial Configuration Port

This block is the slave side of a configuration port. It loads a small bank of setting registers from a serial host, and the host can use either of two protocols on the same clock and data pins. A static mode strap picks the protocol. When the strap is high, the port answers a two-wire I2C-style bus: a START, a device address with a direction bit, a register subaddress, then one or more data bytes, then a STOP. When the strap is low, the port takes 3-wire transfers. Each transfer is framed by a select-enable line and carries an 8-bit subaddress followed by an 8-bit data byte.

The register bank holds a coarse gain target and a fine gain value for each of three colour channels. It also holds an 8-bit clamp code for each channel and a divider word for a clock synthesizer. All of these values are driven as parallel outputs. Two strap pins choose one of four device addresses, so four ports can share one two-wire bus. A disable input freezes the whole port. The serial pins are oversampled by the block clock. They pass through a synchronizer before any edge is detected.

Top module: `serreg_port`

## Requirements
- R1: After reset, every register output reads 0, which is clamp code 0, and `sda_oe` is low.
- R2: In two-wire mode, the port answers only the 7-bit address formed by 5'b10011 followed by `addr_sel[1:0]`, which gives 0x4C to 0x4F, and only when the direction bit (bit 0 of the first byte) is 0. When it answers, `sda_oe` is high during the 9th clock of the address byte, of the subaddress byte and of every data byte.
- R3: In two-wire mode, a frame that carries another address or a direction bit of 1 gets no acknowledge on any byte. That frame changes no register.
- R4: The subaddress map is as follows. Subaddresses 0, 1 and 2 hold the coarse gains of channels 0, 1 and 2, taken from data bits [6:0]. Subaddresses 3, 4 and 5 hold the fine gains, taken from data bits [4:0]. Subaddresses 6, 7 and 8 hold the 8-bit clamp codes. Subaddress 9 loads divider bits [11:8] from data bits [3:0]. Subaddress 10 loads divider bits [7:0]. A write to any other subaddress is acknowledged and has no effect.
- R5: In two-wire mode, the subaddress steps up by one after each data byte, so a burst fills consecutive registers.
- R6: In 3-wire mode, bits are taken on each rising `scl` edge while `sen` is high, MSB first: 8 bits of subaddress, then 8 bits of data. The write takes effect when `sen` falls. `scl` edges while `sen` is low are ignored.
- R7: A 3-wire frame with any bit count other than 16, such as 15 or 17, changes no register.
- R8: While `dis` is high, no register changes in either mode and `sda_oe` stays low.
- R9: With `mode_i2c` high, 3-wire frames have no effect. With `mode_i2c` low, two-wire frames get no acknowledge and have no effect.
- R10: Channel k of the coarse, fine and clamp outputs sits at bits [k*W +: W] of its bus, where W is the field width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i2c | input | 1 | Protocol strap: 1 two-wire, 0 3-wire |
| dis | input | 1 | Port disable, active high |
| addr_sel | input | 2 | Device address strap, low two address bits |
| scl | input | 1 | Serial clock |
| sda | input | 1 | Serial data as seen on the line |
| sen | input | 1 | 3-wire select enable, active high |
| sda_oe | output | 1 | Pull data line low (acknowledge) |
| coarse_gain | output | 21 | Three 7-bit coarse gain targets |
| fine_gain | output | 15 | Three 5-bit fine gain values |
| clamp_code | output | 24 | Three 8-bit clamp codes |
| pll_div | output | 12 | Clock divider word |

## Verification
The case that is hardest to reach is a two-wire burst that runs past the end of the register map. The subaddress keeps counting into unused space while every byte is still acknowledged and no register moves. The stimulus starts such a burst at subaddress 6 and carries it through the divider registers to subaddress 11. The 3-wire framing edges get the same treatment. The bench sends 15-bit and 17-bit frames, and it sends stray clocks while select-enable is low just ahead of a valid frame. A reference model compares every output register on every quiet clock.

// File: rtl/serreg_pkg.sv
package serreg_pkg;
  localparam int NCH        = 3;
  localparam int COARSE_W   = 7;
  localparam int FINE_W     = 5;
  localparam int CLAMP_W    = 8;
  localparam int DIV_W      = 12;
  localparam int SUB_COARSE = 0;
  localparam int SUB_FINE   = 3;
  localparam int SUB_CLAMP  = 6;
  localparam int SUB_DIV_HI = 9;
  localparam int SUB_DIV_LO = 10;

  typedef enum logic [2:0] {
    TW_IDLE, TW_ADDR, TW_SUB, TW_DATA, TW_SKIP
  } tw_state_e;
endpackage

// File: rtl/serreg_sync.sv
module serreg_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] q,
  output logic [N-1:0] q_d
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic s1, s2, s3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
        s3 <= 1'b0;
      end else begin
        s1 <= din[i];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign q[i]   = s2;
    assign q_d[i] = s3;
  end
endmodule

// File: rtl/serreg_twowire.sv
module serreg_twowire
  import serreg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [6:0] dev_addr,
  input  logic       scl,
  input  logic       sda,
  input  logic       scl_d,
  input  logic       sda_d,
  output logic       we_o,
  output logic [7:0] waddr_o,
  output logic [7:0] wdata_o,
  output logic       ack_o
);
  tw_state_e  st_q, st_n;
  logic [3:0] cnt_q, cnt_n;
  logic [7:0] sh_q, sh_n, sub_q, sub_n;
  logic       ack_q, ack_n, we_n;

  logic scl_rise, scl_fall, start_c, stop_c;
  assign scl_rise = scl & ~scl_d;
  assign scl_fall = ~scl & scl_d;
  assign start_c  = scl & scl_d & sda_d & ~sda;
  assign stop_c   = scl & scl_d & ~sda_d & sda;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    sh_n  = sh_q;
    sub_n = sub_q;
    ack_n = ack_q;
    we_n  = 1'b0;
    if (!en) begin
      st_n  = TW_IDLE;
      cnt_n = 4'd0;
      ack_n = 1'b0;
    end else if (start_c) begin
      st_n  = TW_ADDR;
      cnt_n = 4'd0;
      ack_n = 1'b0;
    end else if (stop_c) begin
      st_n  = TW_IDLE;
      cnt_n = 4'd0;
      ack_n = 1'b0;
    end else if (st_q != TW_IDLE && st_q != TW_SKIP) begin
      if (scl_rise && cnt_q < 4'd8) begin
        sh_n  = {sh_q[6:0], sda};
        cnt_n = cnt_q + 4'd1;
      end else if (scl_fall && cnt_q == 4'd8) begin
        cnt_n = 4'd9;
        case (st_q)
          TW_ADDR: begin
            if (sh_q[7:1] == dev_addr && !sh_q[0]) ack_n = 1'b1;
            else begin
              st_n  = TW_SKIP;
              cnt_n = 4'd0;
            end
          end
          TW_SUB: begin
            ack_n = 1'b1;
            sub_n = sh_q;
          end
          TW_DATA: begin
            ack_n = 1'b1;
            we_n  = 1'b1;
          end
          default: ;
        endcase
      end else if (scl_fall && cnt_q == 4'd9) begin
        cnt_n = 4'd0;
        ack_n = 1'b0;
        case (st_q)
          TW_ADDR: st_n  = TW_SUB;
          TW_SUB:  st_n  = TW_DATA;
          TW_DATA: sub_n = sub_q + 8'd1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TW_IDLE;
      cnt_q <= 4'd0;
      sh_q  <= 8'd0;
      sub_q <= 8'd0;
      ack_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      sh_q  <= sh_n;
      sub_q <= sub_n;
      ack_q <= ack_n;
    end
  end

  assign we_o    = we_n;
  assign waddr_o = sub_q;
  assign wdata_o = sh_q;
  assign ack_o   = ack_q;

  // R2
  ack_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> cnt_q == 4'd9);
  // R3
  write_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_o |-> st_q == TW_DATA);
endmodule

// File: rtl/serreg_3wire.sv
module serreg_3wire (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       scl,
  input  logic       sda,
  input  logic       sen,
  input  logic       scl_d,
  input  logic       sen_d,
  output logic       we_o,
  output logic [7:0] waddr_o,
  output logic [7:0] wdata_o
);
  localparam int FRAME = 16;
  localparam logic [4:0] CNT_FULL = 5'(FRAME);
  localparam logic [4:0] CNT_OVER = 5'(FRAME + 1);

  logic [4:0]  cnt_q, cnt_n;
  logic [15:0] sh_q, sh_n;
  logic        scl_rise, sen_fall;

  assign scl_rise = scl & ~scl_d;
  assign sen_fall = ~sen & sen_d;

  always_comb begin
    cnt_n = cnt_q;
    sh_n  = sh_q;
    if (!en || !sen) begin
      cnt_n = 5'd0;
    end else if (scl_rise) begin
      sh_n = {sh_q[14:0], sda};
      if (cnt_q != CNT_OVER) cnt_n = cnt_q + 5'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= 5'd0;
      sh_q  <= 16'd0;
    end else begin
      cnt_q <= cnt_n;
      sh_q  <= sh_n;
    end
  end

  assign we_o    = en & sen_fall & (cnt_q == CNT_FULL);
  assign waddr_o = sh_q[15:8];
  assign wdata_o = sh_q[7:0];

  // R6
  frame_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_o |=> cnt_q == 5'd0);
endmodule

// File: rtl/serreg_regs.sv
module serreg_regs
  import serreg_pkg::*;
#(
  parameter int CH  = NCH,
  parameter int CW  = COARSE_W,
  parameter int FW  = FINE_W,
  parameter int KW  = CLAMP_W,
  parameter int PW  = DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             dis,
  input  logic [7:0]       waddr,
  input  logic [7:0]       wdata,
  output logic [CH*CW-1:0] coarse_o,
  output logic [CH*FW-1:0] fine_o,
  output logic [CH*KW-1:0] clamp_o,
  output logic [PW-1:0]    div_o
);
  localparam int PH = PW - 8;

  logic [CH*CW-1:0] coarse_q, coarse_n;
  logic [CH*FW-1:0] fine_q, fine_n;
  logic [CH*KW-1:0] clamp_q, clamp_n;
  logic [PW-1:0]    div_q, div_n;
  logic             wr;

  assign wr = wr_en & ~dis;

  always_comb begin
    coarse_n = coarse_q;
    fine_n   = fine_q;
    clamp_n  = clamp_q;
    div_n    = div_q;
    for (int i = 0; i < CH; i++) begin
      if (wr && waddr == 8'(SUB_COARSE + i)) coarse_n[i*CW +: CW] = wdata[CW-1:0];
      if (wr && waddr == 8'(SUB_FINE + i))   fine_n[i*FW +: FW]   = wdata[FW-1:0];
      if (wr && waddr == 8'(SUB_CLAMP + i))  clamp_n[i*KW +: KW]  = wdata[KW-1:0];
    end
    if (wr && waddr == 8'(SUB_DIV_HI)) div_n[PW-1:8] = wdata[PH-1:0];
    if (wr && waddr == 8'(SUB_DIV_LO)) div_n[7:0]    = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coarse_q <= '0;
      fine_q   <= '0;
      clamp_q  <= '0;
      div_q    <= '0;
    end else begin
      coarse_q <= coarse_n;
      fine_q   <= fine_n;
      clamp_q  <= clamp_n;
      div_q    <= div_n;
    end
  end

  assign coarse_o = coarse_q;
  assign fine_o   = fine_q;
  assign clamp_o  = clamp_q;
  assign div_o    = div_q;

  // R8
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dis |=> $stable({coarse_q, fine_q, clamp_q, div_q}));
endmodule

// File: rtl/serreg_port.sv
module serreg_port
  import serreg_pkg::*;
#(
  parameter int         CH        = NCH,
  parameter int         CW        = COARSE_W,
  parameter int         FW        = FINE_W,
  parameter int         KW        = CLAMP_W,
  parameter int         PW        = DIV_W,
  parameter logic [6:0] BASE_ADDR = 7'h4C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_i2c,
  input  logic             dis,
  input  logic [1:0]       addr_sel,
  input  logic             scl,
  input  logic             sda,
  input  logic             sen,
  output logic             sda_oe,
  output logic [CH*CW-1:0] coarse_gain,
  output logic [CH*FW-1:0] fine_gain,
  output logic [CH*KW-1:0] clamp_code,
  output logic [PW-1:0]    pll_div
);
  logic       rst_m, rst_s;
  logic [2:0] pin_q, pin_qd;
  logic       tw_we, w3_we, we;
  logic [7:0] tw_addr, tw_data, w3_addr, w3_data, waddr, wdata;
  logic       en_tw, en_w3;
  logic [6:0] dev_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  assign en_tw    = mode_i2c & ~dis;
  assign en_w3    = ~mode_i2c & ~dis;
  assign dev_addr = {BASE_ADDR[6:2], addr_sel};

  serreg_sync #(.N(3)) u_sync (
    .clk(clk), .rst_n(rst_s), .din({sen, sda, scl}), .q(pin_q), .q_d(pin_qd)
  );

  serreg_twowire u_tw (
    .clk(clk), .rst_n(rst_s), .en(en_tw), .dev_addr(dev_addr),
    .scl(pin_q[0]), .sda(pin_q[1]), .scl_d(pin_qd[0]), .sda_d(pin_qd[1]),
    .we_o(tw_we), .waddr_o(tw_addr), .wdata_o(tw_data), .ack_o(sda_oe)
  );

  serreg_3wire u_w3 (
    .clk(clk), .rst_n(rst_s), .en(en_w3),
    .scl(pin_q[0]), .sda(pin_q[1]), .sen(pin_q[2]),
    .scl_d(pin_qd[0]), .sen_d(pin_qd[2]),
    .we_o(w3_we), .waddr_o(w3_addr), .wdata_o(w3_data)
  );

  assign we    = mode_i2c ? tw_we   : w3_we;
  assign waddr = mode_i2c ? tw_addr : w3_addr;
  assign wdata = mode_i2c ? tw_data : w3_data;

  serreg_regs #(.CH(CH), .CW(CW), .FW(FW), .KW(KW), .PW(PW)) u_regs (
    .clk(clk), .rst_n(rst_s), .wr_en(we), .dis(dis), .waddr(waddr), .wdata(wdata),
    .coarse_o(coarse_gain), .fine_o(fine_gain), .clamp_o(clamp_code), .div_o(pll_div)
  );

  // R9
  w3_quiet_chk: assert property (@(posedge clk) disable iff (!rst_s)
    mode_i2c |-> !w3_we);
  // R9
  tw_quiet_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !mode_i2c |-> (!tw_we && !$rose(sda_oe)));
endmodule

// File: tb/serreg_port_bench.sv
module serreg_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_i2c = 1'b1, dis = 1'b0, scl = 1'b1, sda_drv = 1'b1, sen = 1'b0;
  logic [1:0] addr_sel = 2'd0;
  logic sda_oe, sda_line;
  logic [20:0] coarse_gain;
  logic [14:0] fine_gain;
  logic [23:0] clamp_code;
  logic [11:0] pll_div;

  logic [20:0] e_coarse = '0;
  logic [14:0] e_fine = '0;
  logic [23:0] e_clamp = '0;
  logic [11:0] e_div = '0;
  bit settled = 1'b0;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_drv & ~sda_oe;

  serreg_port u_serreg_port (
    .clk(clk), .rst_n(rst_n), .mode_i2c(mode_i2c), .dis(dis), .addr_sel(addr_sel),
    .scl(scl), .sda(sda_line), .sen(sen), .sda_oe(sda_oe),
    .coarse_gain(coarse_gain), .fine_gain(fine_gain), .clamp_code(clamp_code),
    .pll_div(pll_div)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model compared on every quiet clock (R4, R10)
  always @(negedge clk) begin
    if (settled) begin
      check("R4/R10 coarse", 32'(coarse_gain), 32'(e_coarse));
      check("R4/R10 fine", 32'(fine_gain), 32'(e_fine));
      check("R4/R10 clamp", 32'(clamp_code), 32'(e_clamp));
      check("R4 divider", 32'(pll_div), 32'(e_div));
    end
  end

  task automatic model_write(input int sub, input logic [7:0] d);
    if (sub >= 0 && sub <= 2)      e_coarse[sub*7 +: 7]     = d[6:0];
    else if (sub >= 3 && sub <= 5) e_fine[(sub-3)*5 +: 5]   = d[4:0];
    else if (sub >= 6 && sub <= 8) e_clamp[(sub-6)*8 +: 8]  = d;
    else if (sub == 9)             e_div[11:8]              = d[3:0];
    else if (sub == 10)            e_div[7:0]               = d;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tw_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i];
      wait_clk(HB); scl = 1'b1;
      wait_clk(HB); scl = 1'b0;
    end
    sda_drv = 1'b1;
    wait_clk(HB); scl = 1'b1;
    wait_clk(HB/2); acked = sda_oe;
    wait_clk(HB/2); scl = 1'b0;
  endtask

  task automatic tw_frame(input string req, input logic [6:0] addr, input bit rw,
                          input int sub, input logic [7:0] data[$]);
    bit acked, exp_ack;
    exp_ack = mode_i2c && !dis && (addr == {5'b10011, addr_sel}) && !rw;
    settled = 1'b0;
    sda_drv = 1'b0; wait_clk(HB); scl = 1'b0; wait_clk(HB);
    tw_byte({addr, rw}, acked);
    check({req, " ack addr"}, 32'(acked), 32'(exp_ack));
    tw_byte(8'(sub), acked);
    check({req, " ack sub"}, 32'(acked), 32'(exp_ack));
    foreach (data[k]) begin
      tw_byte(data[k], acked);
      check({req, " ack data"}, 32'(acked), 32'(exp_ack));
      if (exp_ack) model_write(sub + k, data[k]);
    end
    sda_drv = 1'b0; wait_clk(HB); scl = 1'b1; wait_clk(HB); sda_drv = 1'b1;
    wait_clk(2*HB);
    settled = 1'b1;
    wait_clk(4);
  endtask

  task automatic w3_frame(input int nbits, input logic [31:0] bits);
    settled = 1'b0;
    sen = 1'b1; wait_clk(HB);
    for (int i = nbits - 1; i >= 0; i--) begin
      sda_drv = bits[i];
      wait_clk(HB); scl = 1'b1;
      wait_clk(HB); scl = 1'b0;
    end
    wait_clk(HB); sen = 1'b0; sda_drv = 1'b1;
    if (nbits == 16 && !mode_i2c && !dis) model_write(int'(bits[15:8]), bits[7:0]);
    wait_clk(2*HB);
    settled = 1'b1;
    wait_clk(4);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(6);
    // R1 reset state
    check("R1 coarse", 32'(coarse_gain), 0);
    check("R1 fine", 32'(fine_gain), 0);
    check("R1 clamp", 32'(clamp_code), 0);
    check("R1 divider", 32'(pll_div), 0);
    check("R1 ack idle", 32'(sda_oe), 0);
    settled = 1'b1;

    // R2 R5 R10 burst from subaddress 0
    tw_frame("R2 R5", 7'h4C, 1'b0, 0, '{8'h15, 8'h2A, 8'h40, 8'h11});
    // R4 field masking on fine gains
    tw_frame("R4 mask", 7'h4C, 1'b0, 3, '{8'hFF, 8'hFF, 8'hFF});
    tw_frame("R4 mask coarse", 7'h4C, 1'b0, 1, '{8'hFF});
    // R3 wrong address and read direction
    addr_sel = 2'd1;
    tw_frame("R3 wrong addr", 7'h4E, 1'b0, 0, '{8'h00, 8'h00});
    tw_frame("R3 read bit", 7'h4D, 1'b1, 0, '{8'h00});
    // R2 R5 R4 burst through clamps, divider and unused space
    addr_sel = 2'd3;
    tw_frame("R2 R4 R5", 7'h4F, 1'b0, 6, '{8'h80, 8'hFF, 8'h01, 8'hA5, 8'h3C, 8'h77});
    tw_frame("R4 unused", 7'h4F, 1'b0, 8'h20, '{8'h55});
    // R8 disable in two-wire mode
    dis = 1'b1;
    tw_frame("R8 tw dis", 7'h4F, 1'b0, 0, '{8'h01});
    check("R8 ack low", 32'(sda_oe), 0);
    dis = 1'b0;
    // R9 two-wire frame in 3-wire mode
    mode_i2c = 1'b0; wait_clk(4);
    tw_frame("R9 tw in 3w", 7'h4F, 1'b0, 0, '{8'h02});
    // R6 3-wire frames, stray clocks while sen low first
    for (int i = 0; i < 5; i++) begin
      sda_drv = 1'b1; wait_clk(HB); scl = 1'b1; wait_clk(HB); scl = 1'b0;
    end
    w3_frame(16, {16'h0, 8'd1, 8'h55});
    w3_frame(16, {16'h0, 8'd7, 8'h99});
    w3_frame(16, {16'h0, 8'd10, 8'hC3});
    // R7 wrong bit counts
    w3_frame(15, {17'h0, 7'd2, 8'h33});
    w3_frame(17, {15'h0, 1'b0, 8'd2, 8'h33});
    // R8 disable in 3-wire mode
    dis = 1'b1;
    w3_frame(16, {16'h0, 8'd0, 8'h7E});
    dis = 1'b0;
    // R9 3-wire frame in two-wire mode
    mode_i2c = 1'b1; wait_clk(4);
    w3_frame(16, {16'h0, 8'd0, 8'h6B});
    // final explicit check of packing, R10
    check("R10 ch1 coarse", 32'(coarse_gain[13:7]), 32'h55);
    check("R10 ch1 clamp", 32'(clamp_code[15:8]), 32'h99);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule